// File: doc/BRIEF.md
# Asynchronous EDO DRAM Device Emulator

This block sits on the device side of a multiplexed-address DRAM bus. It lets an external controller, which drives row and column strobes in the usual asynchronous way, reach an on-chip synchronous RAM as if it were an extended-data-out DRAM with two byte lanes. Every strobe, the 8-bit address and the write data are oversampled by a fast local clock. The block then works out, from the order in which the strobes change, whether a cycle latches a row, accesses a column, or is one of two kinds of refresh.

A row strobe that falls while both column strobes are high latches the row. Each later fall of the column strobes, while the row strobe stays low, latches a column and reads or writes the lanes whose column strobes are low. Any number of such column cycles may run within one row. Read data stays on the bus after the column strobe rises, in the manner of extended data out. The output is split into a data word and one drive enable per byte lane, so that the pad ring can build the tri-state bus. A column strobe that falls before the row strobe marks a refresh with no data transfer. A row cycle that has no column activity is a row-only refresh. Each kind of refresh has its own counter.

The internal array is `2**ROW_USE` rows by `2**COL_USE` columns of 16 bits. Address bits above these widths alias. Setting both widths to 8 gives the full 64K-word map.

Top module: `edo_dram_emu`

## Requirements
- R1: During reset and in the first cycle after it, both lane enables `dq_oe` are 0 and both refresh counters read 0.
- R2: When `ras_n` falls while `ucas_n` and `lcas_n` are both high, `addr` is latched as the row for the column cycles that follow.
- R3: When `ras_n` is low and the column strobes go from both high to at least one low, `addr` is latched as the column. If `we_n` is low, the word at {row, column} is written from `dq_in` only in the lanes whose strobe is low. Lane 0 is `dq_in[7:0]` under `lcas_n`, and lane 1 is `dq_in[15:8]` under `ucas_n`.
- R4: A column access with `we_n` high loads the stored word onto `dq_out` and sets `dq_oe[0]` when `lcas_n` is low and `dq_oe[1]` when `ucas_n` is low. The other lane stays undriven. Every pin change takes effect 3 clock edges after it is applied: two synchronizer stages and one decode stage.
- R5: After a read, the lane enables and `dq_out` are held when the column strobes rise. They are replaced only at the next column access or cleared when `ras_n` rises.
- R6: `dq_oe` is 0 while the synchronized `oe_n` is high. Held read data returns to the bus when `oe_n` goes low again.
- R7: With `ras_n` high for more than one synchronized sample, `dq_oe` is 0.
- R8: Several column cycles within one low period of `ras_n` all use the same latched row, and the column can range over all `2**COL_USE` values.
- R9: If a column strobe is low when `ras_n` falls, `cbr_count` increments by one. That row cycle performs no write and drives no data, whatever `we_n` and `dq_in` hold.
- R10: A row cycle opened by R2 that ends with `ras_n` rising without any column access increments `ras_only_count` by one. Row cycles that had a column access do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| dq_in | input | 2*LANE_W | Data from the bus pads |
| dq_out | output | 2*LANE_W | Data toward the bus pads |
| dq_oe | output | 2 | Per-lane pad drive enable |
| cbr_count | output | CNT_W | Column-before-row refresh count |
| ras_only_count | output | CNT_W | Row-only refresh count |

## Verification
The hardest state to reach from the ports is extended-data hold interleaved with output-enable toggling. Here a read has finished, the column strobes are back high, the row is still open, and the controller then pulses `oe_n` before the next column cycle starts. The stimulus opens a row, runs byte-lane reads, raises the column strobe, and toggles `oe_n` for several cycles. It also runs a refresh with a column strobe low early while `we_n` is low and new data sits on `dq_in`. A later read of the same location then shows that no write happened. A behavioural model with its own sample queue follows every clock.

// File: rtl/edo_pkg.sv
// Shared definitions for the EDO DRAM device emulator.
// Assumes exactly two byte lanes, each with its own column strobe.
package edo_pkg;
    localparam int LANES = 2;

    // Kind of the current row-strobe cycle.
    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_ACCESS  = 2'd1,
        CYC_REFRESH = 2'd2
    } cyc_t;
endpackage

// File: rtl/edo_sync.sv
// Two-stage synchronizer for a vector of asynchronous pins.
// Assumes the pins are held stable for several clocks around each strobe edge,
// so the bits of a bus resolve together.
module edo_sync #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic meta;
            // Two flops per bit; reset puts the pin in its inactive level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta <= RST_VAL[i];
                    q[i] <= RST_VAL[i];
                end else begin
                    meta <= d[i];
                    q[i] <= meta;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/edo_ram.sv
// Synchronous single-port RAM with per-lane write masks and a registered read.
// Assumes the caller issues at most one access per clock.
module edo_ram #(
    parameter int LANE_W = 8,
    parameter int MEM_AW = 10
) (
    input  logic                             clk,
    input  logic                             en,
    input  logic                             we,
    input  logic [edo_pkg::LANES-1:0]        be,
    input  logic [MEM_AW-1:0]                addr,
    input  logic [edo_pkg::LANES*LANE_W-1:0] wdata,
    output logic [edo_pkg::LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    generate
        for (genvar l = 0; l < edo_pkg::LANES; l++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];
            // One lane: masked write, or read into the output register.
            always_ff @(posedge clk) begin
                if (en && we && be[l]) begin
                    mem[addr] <= wdata[l*LANE_W +: LANE_W];
                end
                if (en && !we) begin
                    rdata[l*LANE_W +: LANE_W] <= mem[addr];
                end
            end
        end
    endgenerate

    // R3: a write always targets at least one lane.
    a_r3_write_has_lane: assert property (@(posedge clk) (en && we) |-> (be != '0));
endmodule

// File: rtl/edo_seq.sv
// Strobe-order decoder: turns synchronized strobe edges into row latches,
// column accesses, refresh counts and per-lane read drive.
// Assumes synchronized inputs; the comparison with the previous sample
// gives the edges.
module edo_seq
    import edo_pkg::*;
#(
    parameter int AW      = 8,
    parameter int ROW_USE = 2,
    parameter int COL_USE = 8,
    parameter int CNT_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       s_ras,
    input  logic                       s_ucas,
    input  logic                       s_lcas,
    input  logic                       s_we,
    input  logic [AW-1:0]              s_addr,
    output logic                       mem_en,
    output logic                       mem_we,
    output logic [LANES-1:0]           mem_be,
    output logic [ROW_USE+COL_USE-1:0] mem_addr,
    output logic [LANES-1:0]           drive,
    output logic [CNT_W-1:0]           cbr_cnt,
    output logic [CNT_W-1:0]           ro_cnt
);
    logic               prev_ras, prev_ucas, prev_lcas;
    cyc_t               cyc;
    logic [ROW_USE-1:0] row_q;
    logic               saw_col;
    logic               ras_fall, ras_rise, cas_idle_now, cas_idle_prev, col_evt;
    logic [LANES-1:0]   lanes;

    // Edge and strobe-order decode from the current and previous sample.
    always_comb begin
        ras_fall      = prev_ras & ~s_ras;
        ras_rise      = ~prev_ras & s_ras;
        cas_idle_now  = s_ucas & s_lcas;
        cas_idle_prev = prev_ucas & prev_lcas;
        lanes         = {~s_ucas, ~s_lcas};
        col_evt       = cas_idle_prev & ~cas_idle_now & ~s_ras & (cyc == CYC_ACCESS);
    end

    // Memory request for a column access.
    always_comb begin
        mem_en   = col_evt;
        mem_we   = ~s_we;
        mem_be   = lanes;
        mem_addr = {row_q, s_addr[COL_USE-1:0]};
    end

    // Cycle state, row latch, refresh counters and read drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ras  <= 1'b1;
            prev_ucas <= 1'b1;
            prev_lcas <= 1'b1;
            cyc       <= CYC_IDLE;
            row_q     <= '0;
            saw_col   <= 1'b0;
            drive     <= '0;
            cbr_cnt   <= '0;
            ro_cnt    <= '0;
        end else begin
            prev_ras  <= s_ras;
            prev_ucas <= s_ucas;
            prev_lcas <= s_lcas;
            if (ras_fall) begin
                if (cas_idle_now) begin
                    cyc     <= CYC_ACCESS;
                    row_q   <= s_addr[ROW_USE-1:0];
                    saw_col <= 1'b0;
                end else begin
                    cyc     <= CYC_REFRESH;
                    cbr_cnt <= cbr_cnt + 1'b1;
                end
            end else if (ras_rise) begin
                if (cyc == CYC_ACCESS && !saw_col) begin
                    ro_cnt <= ro_cnt + 1'b1;
                end
                cyc   <= CYC_IDLE;
                drive <= '0;
            end else if (col_evt) begin
                saw_col <= 1'b1;
                drive   <= s_we ? lanes : '0;
            end
        end
    end

    // R9: a refresh cycle never drives the bus.
    a_r9_refresh_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_REFRESH) |-> (drive == '0));
    // R4: a lane starts driving only after a read column access.
    a_r4_drive_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        ((drive & ~$past(drive)) != '0) |-> ($past(col_evt) && $past(s_we)));
    // R9: the refresh count steps by one, and only on a row-strobe fall.
    a_r9_cbr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cbr_cnt != $past(cbr_cnt)) |-> ((cbr_cnt == CNT_W'($past(cbr_cnt) + 1'b1)) && $past(ras_fall)));
    // R10: the row-only count steps by one, and only on a row-strobe rise.
    a_r10_ro_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_cnt != $past(ro_cnt)) |-> ((ro_cnt == CNT_W'($past(ro_cnt) + 1'b1)) && $past(ras_rise)));
endmodule

// File: rtl/edo_dram_emu.sv
// Top level of the EDO DRAM device emulator: synchronizes the pins, decodes
// the strobe order and serves accesses from an internal synchronous RAM.
// Assumes the controller holds address and data stable around each strobe
// edge for at least three clocks.
module edo_dram_emu #(
    parameter int AW      = 8,
    parameter int LANE_W  = 8,
    parameter int ROW_USE = 2,
    parameter int COL_USE = 8,
    parameter int CNT_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic                ucas_n,
    input  logic                lcas_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [AW-1:0]       addr,
    input  logic [2*LANE_W-1:0] dq_in,
    output logic [2*LANE_W-1:0] dq_out,
    output logic [1:0]          dq_oe,
    output logic [CNT_W-1:0]    cbr_count,
    output logic [CNT_W-1:0]    ras_only_count
);
    localparam int DW     = edo_pkg::LANES * LANE_W;
    localparam int MEM_AW = ROW_USE + COL_USE;
    localparam int SW     = 5 + AW + DW;
    localparam logic [SW-1:0] SYNC_RST = {5'b11111, {(AW + DW){1'b0}}};

    logic [SW-1:0]       s_vec;
    logic                s_ras, s_ucas, s_lcas, s_we, s_oe;
    logic [AW-1:0]       s_addr;
    logic [DW-1:0]       s_dq;
    logic                mem_en, mem_we;
    logic [1:0]          mem_be, drive;
    logic [MEM_AW-1:0]   mem_addr;

    edo_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ras_n, ucas_n, lcas_n, we_n, oe_n, addr, dq_in}),
        .q     (s_vec)
    );

    // Split the synchronized vector back into pins.
    always_comb begin
        {s_ras, s_ucas, s_lcas, s_we, s_oe, s_addr, s_dq} = s_vec;
    end

    edo_seq #(.AW(AW), .ROW_USE(ROW_USE), .COL_USE(COL_USE), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_ras    (s_ras),
        .s_ucas   (s_ucas),
        .s_lcas   (s_lcas),
        .s_we     (s_we),
        .s_addr   (s_addr),
        .mem_en   (mem_en),
        .mem_we   (mem_we),
        .mem_be   (mem_be),
        .mem_addr (mem_addr),
        .drive    (drive),
        .cbr_cnt  (cbr_count),
        .ro_cnt   (ras_only_count)
    );

    edo_ram #(.LANE_W(LANE_W), .MEM_AW(MEM_AW)) u_ram (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .be    (mem_be),
        .addr  (mem_addr),
        .wdata (s_dq),
        .rdata (dq_out)
    );

    // Output gating: held drive qualified by the synchronized output enable.
    always_comb begin
        dq_oe = drive & {2{~s_oe}};
    end

    // R7: once the row strobe has been high for two samples, the bus is idle.
    a_r7_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_ras) && s_ras) |-> (dq_oe == 2'b00));
    // R6: output-enable high always releases the bus.
    a_r6_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        s_oe |-> (dq_oe == 2'b00));
endmodule

// File: tb/sim_edo_dram_emu.sv
`timescale 1ns/1ps
// Bench: drives strobe sequences and compares, on every clock, against a
// behavioural model that keeps its own queue of pin samples.
module sim_edo_dram_emu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic [15:0] cbr_count, ras_only_count;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edo_dram_emu u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .cbr_count(cbr_count), .ras_only_count(ras_only_count)
    );

    // Reference model. Sample layout: [28]ras [27]ucas [26]lcas [25]we [24]oe [23:16]addr [15:0]dq
    localparam logic [28:0] IDLE_PINS = {5'b11111, 24'h0};
    logic [28:0] q_a, q_b, q_c;
    logic [15:0] mmem [0:1023];
    int          m_kind;          // 0 idle, 1 access, 2 refresh
    logic [1:0]  m_row;
    bit          m_saw;
    logic [1:0]  m_drive;
    logic [15:0] m_data;
    int          m_cbr, m_ro;
    logic [1:0]  e_oe;

    always @(posedge clk) begin
        if (!rst_n) begin
            q_a = IDLE_PINS; q_b = IDLE_PINS; q_c = IDLE_PINS;
            m_kind = 0; m_row = '0; m_saw = 0; m_drive = '0;
            m_cbr = 0; m_ro = 0; e_oe = '0;
        end else begin
            if (q_c[28] && !q_b[28]) begin
                if (q_b[27] && q_b[26]) begin
                    m_kind = 1; m_row = q_b[17:16]; m_saw = 0;
                end else begin
                    m_kind = 2; m_cbr = m_cbr + 1;
                end
            end else if (!q_c[28] && q_b[28]) begin
                if (m_kind == 1 && !m_saw) m_ro = m_ro + 1;
                m_kind = 0; m_drive = '0;
            end else if (q_c[27] && q_c[26] && !(q_b[27] && q_b[26]) && !q_b[28] && m_kind == 1) begin
                automatic int a = {m_row, q_b[23:16]};
                m_saw = 1;
                if (!q_b[25]) begin
                    if (!q_b[26]) mmem[a][7:0]  = q_b[7:0];
                    if (!q_b[27]) mmem[a][15:8] = q_b[15:8];
                    m_drive = '0;
                end else begin
                    m_data  = mmem[a];
                    m_drive = {!q_b[27], !q_b[26]};
                end
            end
            q_c = q_b; q_b = q_a;
            q_a = {ras_n, ucas_n, lcas_n, we_n, oe_n, addr, dq_in};
            e_oe = m_drive & {2{!q_b[24]}};
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison away from the active edge (R4, R5, R6, R7, R9, R10).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(dq_oe === e_oe, "R4/R5/R6/R7 lane enables", {30'd0, dq_oe}, {30'd0, e_oe});
            if (dq_oe[0]) check(dq_out[7:0] === m_data[7:0], "R4 lower lane data", {24'd0, dq_out[7:0]}, {24'd0, m_data[7:0]});
            if (dq_oe[1]) check(dq_out[15:8] === m_data[15:8], "R4 upper lane data", {24'd0, dq_out[15:8]}, {24'd0, m_data[15:8]});
            check(cbr_count == 16'(m_cbr), "R9 refresh count", {16'd0, cbr_count}, m_cbr);
            check(ras_only_count == 16'(m_ro), "R10 row-only count", {16'd0, ras_only_count}, m_ro);
        end
    end

    task automatic pins(input logic r, input logic u, input logic l, input logic w, input logic o,
                        input logic [7:0] a, input logic [15:0] d, input int n);
        @(negedge clk);
        #0.5;
        ras_n = r; ucas_n = u; lcas_n = l; we_n = w; oe_n = o; addr = a; dq_in = d;
        repeat (n) @(negedge clk);
    endtask

    task automatic open_row(input logic [7:0] row);
        pins(1, 1, 1, 1, 1, row, '0, 2);
        pins(0, 1, 1, 1, 1, row, '0, 4);
    endtask

    task automatic close_row();
        pins(1, 1, 1, 1, 1, '0, '0, 5);
    endtask

    task automatic col_write(input logic [7:0] col, input logic [1:0] ln, input logic [15:0] d);
        pins(0, 1, 1, 0, 1, col, d, 2);
        pins(0, !ln[1], !ln[0], 0, 1, col, d, 5);
        pins(0, 1, 1, 0, 1, col, d, 4);
    endtask

    task automatic col_read(input logic [7:0] col, input logic [1:0] ln);
        pins(0, 1, 1, 1, 0, col, '0, 2);
        pins(0, !ln[1], !ln[0], 1, 0, col, '0, 5);
        pins(0, 1, 1, 1, 0, col, '0, 4);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state, seen while reset is still asserted.
        check(dq_oe == 2'b00, "R1 enables in reset", {30'd0, dq_oe}, 0);
        check(cbr_count == 0 && ras_only_count == 0, "R1 counters in reset", {cbr_count, ras_only_count}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dq_oe == 2'b00, "R1 enables after reset", {30'd0, dq_oe}, 0);

        // R2, R3, R8: page-mode writes within one row, all lane combinations.
        open_row(8'd3);
        col_write(8'd5,   2'b11, 16'hA1B2);
        col_write(8'd6,   2'b11, 16'h1234);
        col_write(8'd6,   2'b01, 16'hFF55);
        col_write(8'd7,   2'b11, 16'h0000);
        col_write(8'd7,   2'b10, 16'h66EE);
        col_write(8'd255, 2'b11, 16'hC0DE);
        close_row();
        open_row(8'd1);
        col_write(8'd5,   2'b11, 16'h7777);
        close_row();

        // R4, R8: reads of full word, lower lane and upper lane in one page.
        open_row(8'd3);
        col_read(8'd5, 2'b11);
        check(dq_oe == 2'b11 && dq_out == 16'hA1B2, "R8 row 3 kept apart from row 1", dq_out, 16'hA1B2);
        col_read(8'd6, 2'b01);
        check(dq_oe == 2'b01 && dq_out[7:0] == 8'h55, "R3 lower-only write", {dq_oe, dq_out}, {2'b01, 16'h0055});
        col_read(8'd7, 2'b10);
        check(dq_oe == 2'b10 && dq_out[15:8] == 8'h66, "R3 upper-only write", {dq_oe, dq_out}, {2'b10, 16'h6600});
        col_read(8'd255, 2'b11);
        check(dq_out == 16'hC0DE, "R8 last column", dq_out, 16'hC0DE);
        // R5, R6: hold after CAS rise, then toggle OE.
        pins(0, 1, 1, 1, 0, 8'd0, '0, 6);
        check(dq_oe == 2'b11, "R5 data held after column strobe rise", {30'd0, dq_oe}, 3);
        pins(0, 1, 1, 1, 1, 8'd0, '0, 5);
        check(dq_oe == 2'b00, "R6 OE high releases bus", {30'd0, dq_oe}, 0);
        pins(0, 1, 1, 1, 0, 8'd0, '0, 5);
        check(dq_oe == 2'b11 && dq_out == 16'hC0DE, "R6 held data returns", dq_out, 16'hC0DE);
        close_row();
        check(dq_oe == 2'b00, "R7 standby after row strobe rise", {30'd0, dq_oe}, 0);

        // R9: CAS-before-RAS refresh with write attempt; R10: row-only refreshes.
        pins(1, 1, 0, 0, 0, 8'd5, 16'hDEAD, 3);
        pins(0, 1, 0, 0, 0, 8'd5, 16'hDEAD, 5);
        pins(0, 1, 1, 0, 0, 8'd5, 16'hDEAD, 2);
        pins(0, 1, 0, 0, 0, 8'd5, 16'hDEAD, 4);
        check(dq_oe == 2'b00, "R9 refresh drives nothing", {30'd0, dq_oe}, 0);
        close_row();
        pins(1, 0, 0, 1, 1, 8'd0, '0, 3);
        pins(0, 0, 0, 1, 1, 8'd0, '0, 5);
        close_row();
        check(cbr_count == 16'd2, "R9 two refreshes counted", {16'd0, cbr_count}, 2);
        for (int i = 0; i < 3; i++) begin
            open_row(8'(i));
            close_row();
        end
        check(ras_only_count == 16'd3, "R10 three row-only refreshes", {16'd0, ras_only_count}, 3);
        open_row(8'd3);
        col_read(8'd5, 2'b11);
        check(dq_out == 16'hA1B2, "R9 refresh left memory unchanged", dq_out, 16'hA1B2);
        close_row();
        check(ras_only_count == 16'd3, "R10 access cycle not counted", {16'd0, ras_only_count}, 3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule